// File: doc/BRIEF.md
# MFM Read Data Separator

This block recovers serial NRZ data and a per-cell bit strobe from a stream of MFM read pulses. It runs on an oversampling clock. A digital window counter splits every bit cell into a clock half and a data half. A rising edge that lands in the data half becomes a 1. A cell whose data half stays quiet becomes a 0. Edges in the clock half only steer the counter phase. Each edge pulls the counter toward the point where the edge sits in the middle of its half-cell. The pull is small in steady state and larger during a set acquisition period.

A read-mode input chooses what drives the loop. When it is high, the loop follows the raw read pulses and emits bits. When it is low, the loop follows a reference clock running at twice the bit rate, so that it stays near the right rate, and no bits are emitted. Any change of read mode halts the counter. The counter then restarts in phase with the first edge that arrives from the newly selected source, and the acquisition period begins again.

Top module: `mfm_sep`

## Requirements
- R1: While reset is held, bit_strobe and bit_data are 0 and acq_fast is 1.
- R2: With read mode high, a cell is 2*HALF_TICKS = 32 ticks long. Ticks 0 to 15 form the clock half and ticks 16 to 31 form the data half. Each cell produces exactly one single-cycle bit_strobe. bit_data is 1 when a rising edge of rd_pulse fell in that cell's data half, and 0 otherwise, even if clock-half pulses were present. Bits come out in the order their cells were received.
- R3: With read mode low, bit_strobe stays 0 whatever rd_pulse does.
- R4: After any change of read mode, the window counter is halted, and no bit_strobe occurs until the first rising edge of the selected input. That edge is taken as the centre of a clock half (tick 8).
- R5: Once acq_fast has dropped, each edge moves the window phase one tick toward centring that edge in its half-cell. The move is limited to the actual offset. A stream displaced 3 ticks late or early therefore shifts the strobe of the next three pulse cells by 2, then 1, then 0 ticks from the aligned position.
- R6: While acq_fast is high, each edge moves the phase by up to 4 ticks, limited to the offset. A 3-tick displacement is therefore absorbed in a single cell.
- R7: acq_fast rises on reset and on every read-mode change. It stays high until the 8th cell boundary after that event and then drops.
- R8: In read mode, edges of ref_2f have no effect on the bits or the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, HALF_TICKS ticks per half-cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_mode | input | 1 | High: follow read pulses and emit bits; low: follow reference clock |
| rd_pulse | input | 1 | Raw MFM read pulses, rising edge marks a flux transition |
| ref_2f | input | 1 | Reference square wave at twice the bit rate |
| bit_data | output | 1 | Recovered NRZ bit, valid with bit_strobe |
| bit_strobe | output | 1 | One-cycle pulse per recovered cell |
| acq_fast | output | 1 | High while the loop uses the large correction step |

## Verification
The main decode path is driven with every 6-bit word laid end to end as MFM. This covers all pulse spacings of one, one and a half and two cells, and it shows whether clock-half pulses are wrongly counted as data. A run of zero cells with a one-off 3-tick phase step is then applied. Separate runs place the step late during the acquisition period, late after it, and early after it. The per-cell strobe timing in these runs shows apart the fast step, the slow step and the direction of correction. Quiet stretches after each mode change, and a pulse stream sent while in reference mode, show that the counter really halts and that output is gated.

// File: rtl/mfm_sep_pkg.sv
package mfm_sep_pkg;
   // Run state of the window counter
   typedef enum logic {
      WIN_HALT = 1'b0,
      WIN_RUN  = 1'b1
   } win_state_e;

   // Per-edge phase error classification
   typedef struct packed {
      logic late;
      logic early;
   } ph_err_t;
endpackage

// File: rtl/mfm_sep_sync.sv
module mfm_sep_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic q,
   output logic q_d
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= din;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], din};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_d <= 1'b0;
      else        q_d <= chain[STAGES-1];
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mfm_sep_window.sv
module mfm_sep_window
   import mfm_sep_pkg::*;
#(
   parameter int HALF_TICKS = 16,
   parameter int SLOW_STEP  = 1,
   parameter int FAST_STEP  = 4,
   parameter int ACQ_CELLS  = 8,
   localparam int PH_W      = $clog2(2*HALF_TICKS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic            edge_i,
   output logic [PH_W-1:0] ph,
   output logic            run,
   output logic            wrap,
   output logic            fast
);
   localparam int POS_W = $clog2(HALF_TICKS);
   localparam logic [POS_W-1:0] CENTER = POS_W'(HALF_TICKS/2);
   localparam logic [PH_W-1:0]  LAST   = PH_W'(2*HALF_TICKS-1);
   localparam logic [PH_W-1:0]  START  = PH_W'(HALF_TICKS/2 + 1);
   localparam logic [POS_W-1:0] SLOW_V = POS_W'(SLOW_STEP);
   localparam logic [POS_W-1:0] FAST_V = POS_W'(FAST_STEP);

   win_state_e        state, state_n;
   logic [PH_W-1:0]   ph_n;
   logic [POS_W-1:0]  pos, mag, amt, step_v;
   ph_err_t           perr;

   assign pos        = ph[POS_W-1:0];
   assign perr.late  = pos > CENTER;
   assign perr.early = pos < CENTER;
   assign mag        = perr.late ? (pos - CENTER) : (CENTER - pos);
   assign step_v     = fast ? FAST_V : SLOW_V;
   assign amt        = (mag < step_v) ? mag : step_v;
   assign run        = (state == WIN_RUN);

   always_comb begin
      state_n = state;
      ph_n    = ph;
      wrap    = 1'b0;
      if (restart) begin
         state_n = WIN_HALT;
         ph_n    = '0;
      end else if (state == WIN_HALT) begin
         if (edge_i) begin
            state_n = WIN_RUN;
            ph_n    = START;
         end
      end else begin
         if (edge_i && perr.late)
            ph_n = ph + PH_W'(1) - {{(PH_W-POS_W){1'b0}}, amt};
         else if (edge_i && perr.early)
            ph_n = ph + PH_W'(1) + {{(PH_W-POS_W){1'b0}}, amt};
         else
            ph_n = ph + PH_W'(1);
         wrap = (ph == LAST) && !(edge_i && perr.late);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= WIN_HALT;
         ph    <= '0;
      end else begin
         state <= state_n;
         ph    <= ph_n;
      end
   end

   generate
      if (ACQ_CELLS > 0) begin : g_acq
         localparam int AW = $clog2(ACQ_CELLS+1);
         logic [AW-1:0] acq_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     acq_cnt <= AW'(ACQ_CELLS);
            else if (restart)               acq_cnt <= AW'(ACQ_CELLS);
            else if (wrap && acq_cnt != '0) acq_cnt <= acq_cnt - AW'(1);
         end
         assign fast = (acq_cnt != '0);
      end else begin : g_no_acq
         assign fast = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/mfm_sep_decide.sv
module mfm_sep_decide (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic mode,
   input  logic edge_i,
   input  logic data_half,
   input  logic wrap,
   output logic bit_data,
   output logic bit_strobe
);
   logic hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit        <= 1'b0;
         bit_data   <= 1'b0;
         bit_strobe <= 1'b0;
      end else begin
         bit_strobe <= wrap && mode;
         if (wrap && mode)
            bit_data <= hit || (edge_i && data_half);
         if (clear || wrap)
            hit <= 1'b0;
         else if (edge_i && data_half)
            hit <= 1'b1;
      end
   end
endmodule

// File: rtl/mfm_sep.sv
module mfm_sep #(
   parameter int HALF_TICKS  = 16,
   parameter int SLOW_STEP   = 1,
   parameter int FAST_STEP   = 4,
   parameter int ACQ_CELLS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_mode,
   input  logic rd_pulse,
   input  logic ref_2f,
   output logic bit_data,
   output logic bit_strobe,
   output logic acq_fast
);
   localparam int PH_W  = $clog2(2*HALF_TICKS);
   localparam int N_IN  = 3;
   localparam int I_MOD = 0;
   localparam int I_RD  = 1;
   localparam int I_REF = 2;

   generate
      if (HALF_TICKS < 4 || (HALF_TICKS & (HALF_TICKS-1)) != 0) begin : g_bad_half
         $error("HALF_TICKS must be a power of two of at least 4");
      end
      if (SLOW_STEP < 1 || FAST_STEP < SLOW_STEP || FAST_STEP >= HALF_TICKS/2) begin : g_bad_step
         $error("need 1 <= SLOW_STEP <= FAST_STEP < HALF_TICKS/2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (ACQ_CELLS < 0) begin : g_bad_acq
         $error("ACQ_CELLS must not be negative");
      end
   endgenerate

   logic [N_IN-1:0] raw_in, syn_q, syn_qd;
   assign raw_in = {ref_2f, rd_pulse, rd_mode};

   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_sync
         mfm_sep_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_in[i]),
            .q     (syn_q[i]),
            .q_d   (syn_qd[i])
         );
      end
   endgenerate

   logic mode_s, restart, rd_rise, ref_rise, sel_edge;
   assign mode_s   = syn_q[I_MOD];
   assign restart  = syn_q[I_MOD] ^ syn_qd[I_MOD];
   assign rd_rise  = syn_q[I_RD]  & ~syn_qd[I_RD];
   assign ref_rise = syn_q[I_REF] & ~syn_qd[I_REF];
   assign sel_edge = mode_s ? rd_rise : ref_rise;

   logic [PH_W-1:0] win_ph;
   logic            win_run, win_wrap;

   mfm_sep_window #(
      .HALF_TICKS (HALF_TICKS),
      .SLOW_STEP  (SLOW_STEP),
      .FAST_STEP  (FAST_STEP),
      .ACQ_CELLS  (ACQ_CELLS)
   ) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .edge_i  (sel_edge),
      .ph      (win_ph),
      .run     (win_run),
      .wrap    (win_wrap),
      .fast    (acq_fast)
   );

   mfm_sep_decide u_decide (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (restart),
      .mode       (mode_s),
      .edge_i     (sel_edge),
      .data_half  (win_ph[PH_W-1]),
      .wrap       (win_wrap),
      .bit_data   (bit_data),
      .bit_strobe (bit_strobe)
   );
endmodule

// File: rtl/mfm_sep_chk.sv
module mfm_sep_chk #(
   parameter int HALF_TICKS = 16,
   parameter int ACQ_CELLS  = 8,
   localparam int PH_W      = $clog2(2*HALF_TICKS)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bit_strobe,
   input logic            acq_fast,
   input logic            mode_s,
   input logic            restart,
   input logic            sel_edge,
   input logic            run,
   input logic [PH_W-1:0] ph
);
   localparam logic [PH_W-1:0] START = PH_W'(HALF_TICKS/2 + 1);

   a_r3_strobe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      bit_strobe |-> $past(mode_s));

   a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      bit_strobe |=> !bit_strobe);

   a_r4_restart_halts: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!run && ph == '0));

   a_r4_first_edge_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && sel_edge && !restart) |=> (run && ph == START));

   a_r4_halt_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !$past(run)) |-> !bit_strobe);

   generate
      if (ACQ_CELLS > 0) begin : g_fast
         a_r7_fast_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> acq_fast);
      end
   endgenerate
endmodule

bind mfm_sep mfm_sep_chk #(
   .HALF_TICKS (HALF_TICKS),
   .ACQ_CELLS  (ACQ_CELLS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bit_strobe (bit_strobe),
   .acq_fast   (acq_fast),
   .mode_s     (mode_s),
   .restart    (restart),
   .sel_edge   (sel_edge),
   .run        (win_run),
   .ph         (win_ph)
);

// File: tb/mfm_sep_tb.sv
module mfm_sep_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HT   = 16;
   localparam int CELL = 2*HT;
   localparam int ACQ  = 8;
   localparam int MAXN = 512;

   logic clk = 1'b0;
   logic rst_n, rd_mode, rd_pulse, ref_2f;
   logic bit_data, bit_strobe, acq_fast;

   always #(CLK_PERIOD/2) clk = ~clk;

   mfm_sep dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_mode    (rd_mode),
      .rd_pulse   (rd_pulse),
      .ref_2f     (ref_2f),
      .bit_data   (bit_data),
      .bit_strobe (bit_strobe),
      .acq_fast   (acq_fast)
   );

   int errors = 0, checks = 0;
   int cyc = 0, st_n = 0, cell_n = 0, fast_hits = 0, ref_cnt = 0;
   int cs [MAXN];
   int st [MAXN];
   bit sb [MAXN];
   bit seq [MAXN];
   bit done = 1'b0;

   assign ref_2f = ref_cnt[3];

   always begin
      @(posedge clk); #1;
      ref_cnt = ref_cnt + 1;
   end

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (bit_strobe) begin
         if (st_n < MAXN) begin
            st[st_n] = cyc;
            sb[st_n] = bit_data;
         end
         st_n = st_n + 1;
         if (acq_fast) fast_hits = fast_hits + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         rd_pulse = 1'b0;
      end
   endtask

   task automatic send_cell(input bit cp, input bit dp, input int len, input bit rec);
      for (int j = 0; j < len; j++) begin
         @(posedge clk); #1;
         if (j == 0 && rec) begin
            if (cell_n < MAXN) cs[cell_n] = cyc;
            cell_n++;
         end
         rd_pulse = (cp && (j == HT/2 || j == HT/2+1)) ||
                    (dp && (j == HT+HT/2 || j == HT+HT/2+1));
      end
   endtask

   function automatic int exp_off(input int c);
      case (c)
         14: return -2;
         15: return -1;
         22: return 2;
         23: return 1;
         default: return 0;
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      report();
   end

   initial begin
      int d0, n, pos;
      bit prev;
      rst_n = 1'b0; rd_mode = 1'b0; rd_pulse = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk(bit_strobe == 1'b0, "R1 strobe in reset", int'(bit_strobe), 0);
      chk(bit_data == 1'b0, "R1 data in reset", int'(bit_data), 0);
      chk(acq_fast == 1'b1, "R1 fast in reset", int'(acq_fast), 1);
      @(posedge clk); #1;
      rst_n = 1'b1;

      // R3: reference mode with a live read pulse stream
      st_n = 0;
      for (int c = 0; c < 12; c++) send_cell(c % 2 == 0, c % 3 == 0, CELL, 1'b0);
      idle(4);
      chk(st_n == 0, "R3 strobes in reference mode", st_n, 0);

      // R4/R7: enter read mode, stay quiet
      rd_mode = 1'b1;
      st_n = 0;
      idle(150);
      @(negedge clk);
      chk(st_n == 0, "R4 strobes while halted", st_n, 0);
      chk(acq_fast == 1'b1, "R7 fast after mode change", int'(acq_fast), 1);

      // Session A: zero cells with phase steps
      st_n = 0; cell_n = 0; fast_hits = 0;
      for (int c = 0; c < 28; c++) begin
         if (c == 3 || c == 14) idle(3);
         send_cell(1'b1, 1'b0, (c == 21) ? CELL-3 : CELL, 1'b1);
      end
      idle(2*CELL);
      @(negedge clk);
      chk(st_n >= 28, "R2 strobe count session A", st_n, 28);
      chk(fast_hits == ACQ-1, "R7 strobes seen with fast high", fast_hits, ACQ-1);
      chk(acq_fast == 1'b0, "R7 fast dropped", int'(acq_fast), 0);
      d0 = st[0] - cs[0];
      for (int c = 0; c < 28; c++) begin
         chk(sb[c] == 1'b0, "R2 zero cell", int'(sb[c]), 0);
         if (c == 3)
            chk(st[c]-cs[c] == d0, "R6 fast late step", st[c]-cs[c]-d0, 0);
         else
            chk(st[c]-cs[c] == d0 + exp_off(c), "R5 strobe offset", st[c]-cs[c]-d0, exp_off(c));
      end

      // back to reference, then Session B: all 6-bit words
      rd_mode = 1'b0;
      idle(100);
      rd_mode = 1'b1;
      idle(100);
      @(negedge clk);
      chk(acq_fast == 1'b1, "R7 fast after second change", int'(acq_fast), 1);
      n = 1;
      seq[0] = 1'b0;
      for (int w = 0; w < 64; w++)
         for (int b = 5; b >= 0; b--) begin
            seq[n] = w[b];
            n++;
         end
      st_n = 0; cell_n = 0; prev = 1'b0;
      for (int i = 0; i < n; i++) begin
         send_cell(!prev && !seq[i], seq[i], CELL, 1'b1);
         prev = seq[i];
      end
      idle(2*CELL);
      @(negedge clk);
      chk(st_n >= n, "R2 strobe count sweep", st_n, n);
      pos = 0;
      for (int i = 0; i < n; i++) begin
         if (sb[i] !== seq[i]) pos++;
         chk(sb[i] == seq[i], "R2 R8 swept bit", int'(sb[i]), int'(seq[i]));
      end

      // R1 again: reset in the middle of read mode
      @(posedge clk); #1;
      rst_n = 1'b0;
      @(negedge clk);
      chk(bit_strobe == 1'b0, "R1 strobe after mid-run reset", int'(bit_strobe), 0);
      chk(bit_data == 1'b0, "R1 data after mid-run reset", int'(bit_data), 0);
      chk(acq_fast == 1'b1, "R1 fast after mid-run reset", int'(acq_fast), 1);
      report();
   end
endmodule